// File: doc/BRIEF.md
# Down-Counting System Tick Timer

This block is a 24-bit periodic tick generator that software programs through four 32-bit registers in a 16-byte window. The registers are control/status, reload, current count and a fixed calibration word. Once enabled, the counter steps down by one on every active tick. An active tick is either every core clock or one core clock in eight. When the count goes from one to zero, the block raises a sticky counted-to-zero flag and, if interrupt requests are enabled, drives a one-cycle request pulse. On the next active tick the counter reloads from the reload register, which gives a period of reload+1 ticks.

Software reads the flag to detect elapsed periods, and that read clears the flag. Software restarts a period by writing anything to the current-count register. The block sits on a plain register bus. Writes take effect at the clock edge. Read data is combinational and valid in the same cycle as the read enable.

Top module: `tick_timer`

## Requirements
- R1: After a synchronous active-low reset, control, reload and current count read 0, and the request output is 0.
- R2: The control word keeps enable at bit 0, request-enable at bit 1, source select at bit 2 and the flag at bit 16, and its other bits read 0. Reload and current count keep 24 bits in 23:0, and bits 31:24 read 0. Word offsets are 0x0 control, 0x4 reload, 0x8 current, 0xC calibration. Any access whose low two address bits are nonzero has no effect and reads 0.
- R3: With enable=1 and source select=1, the count changes on every core clock.
- R4: With enable=1 and source select=0, the count changes once every 8 core clocks. The divide-by-8 phase restarts whenever enable is 0, so the first tick comes 8 clocks after the enabling write takes effect.
- R5: A tick at count 1 gives count 0 and sets the flag. A tick at count 0 loads the reload value.
- R6: Each step from 1 to 0 gives a request pulse of exactly one cycle when request-enable is 1, and no pulse when it is 0.
- R7: The flag stays 1 until the control word is read, and that read clears it. If a set and a read fall in the same cycle, the set wins.
- R8: Any write to the current-count register forces the count to 0 and clears the flag, and this takes priority over a tick in the same cycle.
- R9: With reload 0, a count of 0 stays at 0 and produces no further flag or request.
- R10: The calibration word reads 0xC0000000 at all times, and writes to it have no effect.
- R11: While enable is 0, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 4 | Byte address inside the register window |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe, which also clears the flag on a control read |
| rd_data | output | 32 | Read data, zero when rd_en is 0 |
| tick_irq | output | 1 | One-cycle request pulse on each wrap to zero |

## Verification
The hardest situations to reach from the ports are coincidences at single edges. Examples are a control read landing on the same edge as a wrap, a current-count write landing on a tick, and the first divided tick after enable is re-armed. The directed part reaches these by starting from a known count and reload, then counting cycles to place each read or write on the exact wrap edge. It then runs a random mix of register traffic with small reload values, so that such collisions occur often. A cycle-level model in the bench predicts every read and every request bit.

// File: rtl/tick_pkg.sv
// Package: shared register indices, field positions and constants of the
// tick timer. Assumes a 32-bit data path and a 16-byte register window.
package tick_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL    = 2'd0,
        SEL_RELOAD  = 2'd1,
        SEL_CURRENT = 2'd2,
        SEL_CALIB   = 2'd3
    } reg_sel_e;

    localparam int CTRL_EN_BIT    = 0;
    localparam int CTRL_IRQEN_BIT = 1;
    localparam int CTRL_SRC_BIT   = 2;
    localparam int CTRL_FLAG_BIT  = 16;

    localparam logic [31:0] CALIB_WORD = 32'hC000_0000;
endpackage

// File: rtl/tick_prescaler.sv
// Module: tick_prescaler
// Produces the one-cycle count strobe. It fires on every clock when fast_sel
// is 1, and otherwise once per DIV clocks. Assumes run is the registered
// enable bit. The phase counter is held at zero while run is 0.
module tick_prescaler #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fast_sel,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_nodiv
            // No division: both sources tick every enabled clock
            assign tick = run & (fast_sel | 1'b1);
        end else begin : g_div
            localparam int PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] phase_q;

            // Phase counter: restarts while disabled, wraps at DIV-1
            always_ff @(posedge clk) begin
                if (!rst_n)               phase_q <= '0;
                else if (!run)            phase_q <= '0;
                else if (phase_q == LAST) phase_q <= '0;
                else                      phase_q <= phase_q + 1'b1;
            end

            assign tick = run && (fast_sel || (phase_q == LAST));

            // R4
            phase_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !run |=> (phase_q == '0));
            // R4
            slow_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (tick && !fast_sel) |=> !tick || fast_sel);
        end
    endgenerate
endmodule

// File: rtl/tick_counter.sv
// Module: tick_counter
// Holds the down-counter, the sticky counted-to-zero flag and the request
// pulse. Assumes that tick, clear_wr and flag_rd are single-cycle strobes
// decoded by the register block.
module tick_counter #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             irq_en,
    input  logic [CNT_W-1:0] reload,
    input  logic             clear_wr,
    input  logic             flag_rd,
    output logic [CNT_W-1:0] count,
    output logic             flag,
    output logic             irq
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic wrap;
    assign wrap = tick && !clear_wr && (count == ONE);

    // Counter: a write clears it, otherwise it decrements or reloads on a tick
    always_ff @(posedge clk) begin
        if (!rst_n)             count <= '0;
        else if (clear_wr)      count <= '0;
        else if (tick) begin
            if (count == '0)    count <= reload;
            else                count <= count - 1'b1;
        end
    end

    // Sticky flag: a set beats a read-clear, and a count write clears it
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (clear_wr) flag <= 1'b0;
        else if (wrap)     flag <= 1'b1;
        else if (flag_rd)  flag <= 1'b0;
    end

    // Request pulse: one cycle per wrap when enabled
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= wrap && irq_en;
    end

    // R5
    reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clear_wr && count == '0) |=> (count == $past(reload)));
    // R5
    wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clear_wr && count == ONE) |=> (flag && count == '0));
    // R6
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R6
    irq_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (count == '0 && flag));
    // R8
    write_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_wr |=> (count == '0 && !flag && !irq));
    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && reload == '0 && !clear_wr) |=> (count == '0 && !irq));
endmodule

// File: rtl/tick_timer.sv
// Module: tick_timer (top)
// Register block of the tick timer. It decodes the 16-byte window, holds the
// control and reload registers, drives the combinational read mux and feeds
// the prescaler and counter. Assumes only one of rd_en and wr_en is active
// per cycle, and DATA_W >= 32 so that the flag position fits.
module tick_timer #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24,
    parameter int DIV    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              tick_irq
);
    import tick_pkg::*;

    logic             hit;
    reg_sel_e         sel;
    logic             en_q, irqen_q, src_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] count;
    logic             flag;
    logic             tick;
    logic             cur_wr, ctrl_rd;
    logic             unused_wdata;

    assign unused_wdata = ^wr_data;

    generate
        if (ADDR_W > 4) begin : g_wide
            assign hit = (addr[ADDR_W-1:4] == '0) && (addr[1:0] == 2'b00);
        end else begin : g_narrow
            assign hit = (addr[1:0] == 2'b00);
        end
    endgenerate

    assign sel     = reg_sel_e'(addr[3:2]);
    assign cur_wr  = wr_en && hit && (sel == SEL_CURRENT);
    assign ctrl_rd = rd_en && hit && (sel == SEL_CTRL);

    // Control register: enable, request enable, source select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            irqen_q <= 1'b0;
            src_q   <= 1'b0;
        end else if (wr_en && hit && sel == SEL_CTRL) begin
            en_q    <= wr_data[CTRL_EN_BIT];
            irqen_q <= wr_data[CTRL_IRQEN_BIT];
            src_q   <= wr_data[CTRL_SRC_BIT];
        end
    end

    // Reload register: low CNT_W bits of the write data
    always_ff @(posedge clk) begin
        if (!rst_n)                                  reload_q <= '0;
        else if (wr_en && hit && sel == SEL_RELOAD)  reload_q <= wr_data[CNT_W-1:0];
    end

    tick_prescaler #(.DIV(DIV)) i_prescaler (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (en_q),
        .fast_sel (src_q),
        .tick     (tick)
    );

    tick_counter #(.CNT_W(CNT_W)) i_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .irq_en   (irqen_q),
        .reload   (reload_q),
        .clear_wr (cur_wr),
        .flag_rd  (ctrl_rd),
        .count    (count),
        .flag     (flag),
        .irq      (tick_irq)
    );

    // Read mux: zero outside a read or on a misaligned address
    always_comb begin
        rd_data = '0;
        if (rd_en && hit) begin
            unique case (sel)
                SEL_CTRL: begin
                    rd_data[CTRL_EN_BIT]    = en_q;
                    rd_data[CTRL_IRQEN_BIT] = irqen_q;
                    rd_data[CTRL_SRC_BIT]   = src_q;
                    rd_data[CTRL_FLAG_BIT]  = flag;
                end
                SEL_RELOAD:  rd_data = DATA_W'(reload_q);
                SEL_CURRENT: rd_data = DATA_W'(count);
                SEL_CALIB:   rd_data = DATA_W'(CALIB_WORD);
                default:     rd_data = '0;
            endcase
        end
    end

    // R11
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !cur_wr) |=> $stable(count));
    // R7
    flag_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd && !tick) |=> !flag);
endmodule

// File: tb/test_tick_timer.sv
// Bench for tick_timer: directed edge cases, then seeded random register
// traffic. Every cycle is compared against a cycle-level model in the bench.
module test_tick_timer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  addr;
    logic        wr_en, rd_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        tick_irq;

    int n_chk = 0;
    int n_bad = 0;

    // model state
    logic        m_en, m_ie, m_src, m_flag, m_irq;
    logic [23:0] m_reload, m_cur;
    logic [2:0]  m_pre;
    logic        last_irq;

    always #5 clk = ~clk;

    tick_timer i_tick_timer (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .tick_irq(tick_irq)
    );

    function automatic logic [31:0] exp_read(input logic [3:0] a);
        if (a[1:0] != 2'b00) return 32'h0;
        case (a[3:2])
            2'd0:    return {15'h0, m_flag, 13'h0, m_src, m_ie, m_en};
            2'd1:    return {8'h0, m_reload};
            2'd2:    return {8'h0, m_cur};
            default: return 32'hC000_0000;
        endcase
    endfunction

    function automatic string tag_for(input logic [3:0] a);
        if (a[1:0] != 2'b00) return "R2";
        case (a[3:2])
            2'd0:    return "R7";
            2'd1:    return "R2";
            2'd2:    return "R5";
            default: return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step(input logic w, input logic r, input logic [3:0] a,
                              input logic [31:0] d);
        logic        hit, tk, wrap, n_flag;
        logic [23:0] n_cur;
        hit    = (a[1:0] == 2'b00);
        tk     = m_en && (m_src || m_pre == 3'd7);
        wrap   = 1'b0;
        n_cur  = m_cur;
        n_flag = m_flag;
        if (w && hit && a[3:2] == 2'd2) begin
            n_cur  = 24'h0;
            n_flag = 1'b0;
        end else begin
            if (tk) begin
                if (m_cur == 24'd1) begin n_cur = 24'h0; wrap = 1'b1; end
                else if (m_cur == 24'd0) n_cur = m_reload;
                else n_cur = m_cur - 24'd1;
            end
            if (wrap) n_flag = 1'b1;
            else if (r && hit && a[3:2] == 2'd0) n_flag = 1'b0;
        end
        m_irq = wrap && m_ie;
        m_pre = m_en ? m_pre + 3'd1 : 3'd0;
        if (w && hit && a[3:2] == 2'd0) {m_src, m_ie, m_en} = d[2:0];
        if (w && hit && a[3:2] == 2'd1) m_reload = d[23:0];
        m_cur  = n_cur;
        m_flag = n_flag;
    endtask

    // one bus cycle: drive at negedge, compare just before posedge, advance model
    task automatic do_cycle(input logic w, input logic r, input logic [3:0] a,
                            input logic [31:0] d, output logic [31:0] got);
        wr_en = w; rd_en = r; addr = a; wr_data = d;
        #4;
        got      = rd_data;
        last_irq = tick_irq;
        if (r) check(tag_for(a), rd_data, exp_read(a));
        check("R6", {31'h0, tick_irq}, {31'h0, m_irq});
        @(posedge clk);
        model_step(w, r, a, d);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        logic [31:0] g;
        do_cycle(1'b1, 1'b0, a, d, g);
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] g;
        do_cycle(1'b0, 1'b1, a, 32'h0, g);
        check(tag, g, exp);
    endtask

    task automatic idle(input int n);
        logic [31:0] g;
        for (int i = 0; i < n; i++) do_cycle(1'b0, 1'b0, 4'h0, 32'h0, g);
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] g;
        void'($urandom(32'd7741));
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wr_data = '0;
        m_en = 0; m_ie = 0; m_src = 0; m_flag = 0; m_irq = 0;
        m_reload = 0; m_cur = 0; m_pre = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1", {31'h0, tick_irq}, 32'h0);
        rd(4'h0, 32'h0, "R1");
        rd(4'h4, 32'h0, "R1");
        rd(4'h8, 32'h0, "R1");
        // R10 calibration is fixed and read-only
        rd(4'hC, 32'hC000_0000, "R10");
        wr(4'hC, 32'h1234_5678);
        rd(4'hC, 32'hC000_0000, "R10");

        // R2 field masking
        wr(4'h0, 32'hFFFF_FFF8);
        rd(4'h0, 32'h0, "R2");
        wr(4'h4, 32'hAB12_3456);
        rd(4'h4, 32'h0012_3456, "R2");
        wr(4'h5, 32'h0000_0009);
        rd(4'h4, 32'h0012_3456, "R2");
        rd(4'h5, 32'h0, "R2");

        // R3 R5 core-clock countdown with reload 3
        wr(4'h4, 32'd3);
        wr(4'h0, 32'h7);
        rd(4'h8, 32'd0, "R3");
        rd(4'h8, 32'd3, "R5");
        rd(4'h8, 32'd2, "R3");
        rd(4'h8, 32'd1, "R3");
        rd(4'h8, 32'd0, "R5");
        check("R6", {31'h0, last_irq}, 32'd1);
        rd(4'h8, 32'd3, "R5");
        check("R6", {31'h0, last_irq}, 32'd0);
        // R7 read-clear and set-wins collision
        rd(4'h0, 32'h0001_0007, "R7");
        rd(4'h0, 32'h0000_0007, "R7");
        rd(4'h0, 32'h0001_0007, "R7");

        // R8 write to current zeroes count and flag
        wr(4'h8, 32'h55);
        rd(4'h8, 32'd0, "R8");
        rd(4'h0, 32'h7, "R8");

        // R6 no request with request-enable 0
        wr(4'h0, 32'h5);
        for (int i = 0; i < 12; i++) begin
            do_cycle(1'b0, 1'b0, 4'h0, 32'h0, g);
            check("R6", {31'h0, last_irq}, 32'h0);
        end
        rd(4'h0, 32'h0001_0005, "R6");

        // R4 divide-by-8 with fresh phase
        wr(4'h0, 32'h0);
        wr(4'h4, 32'd2);
        wr(4'h8, 32'h0);
        wr(4'h0, 32'h1);
        for (int i = 0; i < 8; i++) rd(4'h8, 32'd0, "R4");
        rd(4'h8, 32'd2, "R4");
        // R11 disabled counter holds
        wr(4'h0, 32'h0);
        for (int i = 0; i < 5; i++) rd(4'h8, 32'd2, "R11");

        // R9 reload zero stops after reaching zero
        wr(4'h4, 32'd0);
        wr(4'h0, 32'h7);
        idle(12);
        rd(4'h0, 32'h0001_0007, "R9");
        idle(12);
        rd(4'h0, 32'h0000_0007, "R9");
        rd(4'h8, 32'd0, "R9");

        // random traffic checked against the model
        for (int i = 0; i < 6000; i++) begin
            int op;
            logic [31:0] d;
            op = $urandom % 16;
            case (op)
                0, 1: begin
                    d = $urandom;
                    d[0] = (($urandom % 4) != 0);
                    wr(4'h0, d);
                end
                2: begin
                    d = (($urandom % 4) == 0) ? $urandom : ($urandom % 6);
                    wr(4'h4, d);
                end
                3: wr(4'h8, $urandom);
                4: wr(4'hC, $urandom);
                5, 6, 7, 8, 9: do_cycle(1'b0, 1'b1, 4'(($urandom % 4) * 4), 32'h0, g);
                default: idle(1);
            endcase
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule